// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Receiver

This block lets a board controller program the control bytes of a clock generator over a two-wire serial bus. It oversamples the bus clock and data lines with its own system clock. It detects start and stop conditions and answers only to its fixed device address in write direction. The answer is an acknowledge: the block pulls the data line low through an open-drain enable. It never drives the line high.

A transfer carries the address byte, then a command byte and a count byte, which are both acknowledged and thrown away. The data bytes that follow fill the configuration registers in a fixed sequence, starting with the first register every time. To change a later register, the host must therefore resend every register before it. The registers hold, in order: frequency select and spread control, CPU clock enables, PCI clock enables, and REF/APIC enable with drive strength. They appear side by side on one wide output bus. Clock enables use 1 for "running", and every enable comes out of reset set.

Top module: `cfg_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high opens a transfer. A rising SDA while SCL is high closes it and releases SDA (`sda_oe` low) within the next clock.
- R2: An address byte of 0xD2 (7-bit address 0x69, bit 0 = 0 for write), sent MSB first, is acknowledged: `sda_oe` is 1 while SCL is high during the ninth clock pulse.
- R3: Any other address byte, including 0xD3 (read), is not acknowledged. The block then ignores the bus until the next start, and no register changes.
- R4: The two bytes after the address are acknowledged. Their contents are discarded, and a transfer that ends after them leaves every register unchanged.
- R5: Data byte k (k = 0, 1, 2, ...) after the two header bytes is acknowledged and written to register k. Register k sits on `cfg_o[8k+7:8k]`, and the first bit received becomes bit 7.
- R6: After reset, register 0 is 0x00 and registers 1 to 3 are 0xFF (all enables set), and `sda_oe` is 0.
- R7: Data bytes beyond the last register are acknowledged, and none of them changes any register.
- R8: A repeated start returns the block to the address phase and keeps every register value. The next data byte again lands in register 0.
- R9: A transfer that stops after N data bytes (N < 4) updates only registers 0 to N-1.
- R10: `sda_oe` changes only while the synchronized SCL is low. A register changes only in the cycle in which an acknowledge begins, and at most one register byte changes per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Serial bus clock line as seen at the pad |
| sda_i | input | 1 | Serial bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| cfg_o | output | 32 | Configuration registers, register k on bits 8k+7:8k |

## Verification
The main same-cycle coincidence is a register write and the start of an acknowledge. Both happen at the SCL fall that ends the eighth bit. The checks compare the register bus against a bench model across that edge, and confirm that the acknowledge starts in the same cycle as the write. The second coincidence is between the end of one transfer and the start of the next: a repeated start lands while the byte counter sits mid-header or mid-data. The bench issues such starts back to back with partial transfers and judges the outcome by which registers hold the old value and which hold the new one.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  // Receive phase of the serial engine
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RECV = 2'd1,
    PH_ACK  = 2'd2
  } phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], line_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_d;
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         HDR_BYTES = 2,
  parameter int         NUM_REGS  = 4,
  localparam int CNT_MAX = HDR_BYTES + NUM_REGS + 1,
  localparam int CNT_W   = $clog2(CNT_MAX + 1),
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             sda_rise,
  input  logic             sda_fall,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

  phase_t           phase_q, phase_d;
  logic [3:0]       bit_q, bit_d;
  logic [CNT_W-1:0] byte_q, byte_d;
  logic [7:0]       sh_q, sh_d;
  logic             oe_q, oe_d;
  logic             start_det, stop_det;
  logic [CNT_W-1:0] data_pos;
  logic             in_range;

  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;
  assign data_pos  = byte_q - CNT_W'(HDR_BYTES + 1);
  assign in_range  = (byte_q > CNT_W'(HDR_BYTES)) &&
                     (byte_q <= CNT_W'(HDR_BYTES + NUM_REGS));

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    if (start_det) begin
      phase_d = PH_RECV;
      bit_d   = 4'd0;
      byte_d  = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (phase_q)
        PH_RECV: begin
          if (scl_rise && bit_q < 4'd8) begin
            sh_d  = {sh_q[6:0], sda_lvl};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (byte_q == '0 && sh_q != ADDR_BYTE) begin
              phase_d = PH_IDLE;
            end else begin
              phase_d = PH_ACK;
              oe_d    = 1'b1;
              wr_en   = in_range;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            phase_d = PH_RECV;
            oe_d    = 1'b0;
            bit_d   = 4'd0;
            if (byte_q < CNT_W'(CNT_MAX)) byte_d = byte_q + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= 4'd0;
      byte_q  <= '0;
      sh_q    <= 8'h00;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_idx  = data_pos[IDX_W-1:0];
  assign wr_data = sh_q;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int                      NUM_REGS = 4,
  parameter logic [NUM_REGS*8-1:0]   RST_VAL  = 32'hFFFF_FF00,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] val_q;
    logic       hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= RST_VAL[g*8 +: 8];
      else if (hit) val_q <= wr_data;
    end
    assign regs_o[g*8 +: 8] = val_q;
  end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0]            DEV_ADDR  = 7'h69,
  parameter int                    HDR_BYTES = 2,
  parameter int                    NUM_REGS  = 4,
  parameter int                    SYNC_STG  = 2,
  parameter logic [NUM_REGS*8-1:0] RST_VAL   = 32'hFFFF_FF00,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  logic             scl_lvl, scl_rise, scl_fall;
  logic             sda_lvl, sda_rise, sda_fall;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  i2c_line_sync #(.STAGES(SYNC_STG)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STG)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c_rx_engine #(
    .DEV_ADDR(DEV_ADDR), .HDR_BYTES(HDR_BYTES), .NUM_REGS(NUM_REGS)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfg_regfile #(.NUM_REGS(NUM_REGS), .RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .regs_o(cfg_o)
  );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int NUM_REGS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_lvl,
  input logic                  sda_rise,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] cfg_o
);
  logic                  seen_q;
  logic [NUM_REGS*8-1:0] prev_q;
  logic [NUM_REGS-1:0]   chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      prev_q <= '0;
    end else begin
      seen_q <= 1'b1;
      prev_q <= cfg_o;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
    assign chg[g] = seen_q && (cfg_o[g*8 +: 8] != prev_q[g*8 +: 8]);
  end

  AST_ACK_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl); // R10

  AST_ACK_RELEASE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_lvl); // R10

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_rise && scl_lvl) |=> !sda_oe); // R1

  AST_ONE_BYTE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= 1); // R10

  AST_WRITE_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |-> $rose(sda_oe)); // R5
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_rise(sda_rise),
  .sda_oe(sda_oe), .cfg_o(cfg_o)
);

// File: tb/sim_cfg_i2c_slave.sv
module sim_cfg_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;   // system clocks per quarter SCL period
  localparam int NR         = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scl_m, sda_m;
  logic          sda_oe;
  logic [NR*8-1:0] cfg_o;
  wire           sda_line = sda_m & ~sda_oe;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] model [NR];
  logic [7:0] dbuf  [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_vec();
    return {model[3], model[2], model[1], model[0]};
  endfunction

  function automatic void model_reset();
    model[0] = 8'h00; model[1] = 8'hFF; model[2] = 8'hFF; model[3] = 8'hFF;
  endfunction

  function automatic void model_write(input logic [7:0] addr, input int n);
    if (addr == 8'hD2)
      for (int k = 0; k < n && k < NR; k++) model[k] = dbuf[k];
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = sda_oe;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  // One transfer: address, two header bytes, n data bytes from dbuf
  task automatic transfer(input logic [7:0] addr, input int n, input logic do_stop);
    logic ack;
    logic exp_ack;
    exp_ack = (addr == 8'hD2);
    bus_start();
    send_byte(addr, ack);
    chk(exp_ack ? "R2 address ack" : "R3 address nack", {31'd0, ack}, {31'd0, exp_ack});
    for (int h = 0; h < 2; h++) begin
      send_byte(8'($urandom), ack);
      chk("R4 header ack", {31'd0, ack}, {31'd0, exp_ack});
    end
    for (int k = 0; k < n; k++) begin
      send_byte(dbuf[k], ack);
      chk(k < NR ? "R5 data ack" : "R7 extra ack", {31'd0, ack}, {31'd0, exp_ack});
    end
    if (do_stop) bus_stop();
    model_write(addr, n);
    tick(4);
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0104));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    model_reset();
    tick(5);
    chk("R6 reset regs", cfg_o, 32'hFFFF_FF00);
    chk("R6 reset sda_oe", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    tick(5);

    // R5: full write, MSB-first placement
    dbuf[0] = 8'h81; dbuf[1] = 8'h5A; dbuf[2] = 8'hC3; dbuf[3] = 8'h24;
    transfer(8'hD2, 4, 1'b1);
    chk("R5 full write", cfg_o, 32'h24C3_5A81);

    // R3: wrong address and read direction leave registers alone
    fill(4);
    transfer(8'hD4, 4, 1'b1);
    chk("R3 wrong address", cfg_o, model_vec());
    fill(4);
    transfer(8'hD3, 4, 1'b1);
    chk("R3 read bit", cfg_o, model_vec());
    chk("R1 released after stop", {31'd0, sda_oe}, 32'd0);

    // R4: header only
    transfer(8'hD2, 0, 1'b1);
    chk("R4 header discarded", cfg_o, model_vec());

    // R9: partial write
    fill(2);
    transfer(8'hD2, 2, 1'b1);
    chk("R9 partial write", cfg_o, model_vec());

    // R7: extra bytes
    fill(7);
    transfer(8'hD2, 7, 1'b1);
    chk("R7 extra bytes", cfg_o, model_vec());

    // R8: repeated start mid-data, then mid-header
    fill(2);
    transfer(8'hD2, 2, 1'b0);
    dbuf[0] = 8'h3C;
    transfer(8'hD2, 1, 1'b1);
    chk("R8 repeated start", cfg_o, model_vec());
    transfer(8'hD2, 0, 1'b0);
    fill(3);
    transfer(8'hD2, 3, 1'b1);
    chk("R8 restart after header", cfg_o, model_vec());

    // Random mix of addresses and lengths
    for (int t = 0; t < 25; t++) begin
      logic [7:0] a;
      int n;
      a = (($urandom % 4) == 0) ? 8'($urandom) : 8'hD2;
      n = $urandom % 7;
      fill(n);
      transfer(a, n, ($urandom % 5) != 0);
      chk((a == 8'hD2) ? "R5 random write" : "R3 random address", cfg_o, model_vec());
    end
    bus_stop();
    tick(4);
    chk("R1 idle at end", {31'd0, sda_oe}, 32'd0);

    summary();
    $finish;
  end
endmodule